// File: doc/BRIEF.md
# Hotspot-Driven Buffer Depth Allocator

This block works out how many buffer slots each of the four mesh-facing input channels of one router should own. It does this from one hotspot flag and one in-use flag per channel and from the nominal per-channel depth D. Its output is a vector of four depths that can drive borrowing input buffers directly. A hotspot channel grows by taking slots from the channels next to it on a ring. An idle neighbour hands over all of its slots. A busy neighbour that is not itself a hotspot keeps a single slot and hands over the rest.

Allocation is a short sequential pass. A start pulse captures the inputs and sets every depth to D. The engine then spends one clock on each channel, in index order 0, 1, 2, 3, and applies the lending rule for the number of hotspots it captured. When the pass ends it raises done. The depths then stay fixed until the next start. Channel indices 0 to 3 form the ring 0→1→2→3→0. The right neighbour of channel i is (i+1) mod 4 and the left neighbour is (i+3) mod 4.

Top module: `slot_lend_allocator`

## Requirements
- R1: While reset is held and directly after it, every depth field reads 0 and both done and busy are low.
- R2: A start pulse sampled at rising edge E0, while the engine is not busy, captures the hotspot flags, the in-use flags and D, and sets every depth to D. Channels are then visited in the order 0, 1, 2, 3 at edges E1 to E4. Done is high directly after E4, and busy is high only between E0 and E4.
- R3: When no hotspot flag is captured, all four final depths equal D.
- R4: When three or four hotspot flags are captured, no lending happens and all four final depths equal D.
- R5: When exactly one hotspot flag is captured, the hotspot channel takes slots first from its right neighbour and then from its left neighbour. An idle neighbour (in-use flag 0) gives D slots. A busy neighbour gives D−1 slots.
- R6: When exactly two hotspot flags are captured, each hotspot channel borrows from one neighbour only. The first matching rule applies: an idle right neighbour gives D; a busy right neighbour that is not a hotspot gives D−1; an idle left neighbour gives D; otherwise the left neighbour gives D−1.
- R7: A transfer never exceeds what the donor holds at that moment, and D−1 is taken as 0 when D is 0. No depth ever wraps below zero.
- R8: After every edge, the four depths add up to exactly 4·D of the latest captured D.
- R9: While done is high and start is low, the depths and done do not change. Input changes, and a start pulse that arrives while busy, have no effect on a pass already running.
- R10: Visits run in index order, so lending between adjacent hotspots follows that order. Channel 0 lends to channel 3 only the slots channel 0 holds after its own visit has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to run an allocation pass |
| hotspotIn | input | 4 | Hotspot flag per channel, bit i = channel i |
| inUseIn | input | 4 | In-use flag per channel, bit i = channel i |
| nomDepth | input | DW | Nominal per-channel depth D |
| depthOut | output | 4·(DW+2) | Final depth of channel i in bits [i·(DW+2) +: DW+2] |
| busy | output | 1 | Pass in progress |
| done | output | 1 | Final depths valid and held |

## Verification
A donor can also be a recipient: channel 0 is both a hotspot that borrows and the right neighbour that channel 3 later borrows from. In the cycle where channel 3 is visited, the lend to channel 3 and the debit from channel 0 both fall on channel 0's state. The bench provokes this with hotspots on channels 3 and 0, channel 0 marked idle. The expected depths are worked out in visit order and checked, together with the four-depth sum. A second overlap is a start pulse and new inputs that arrive while a pass is running. That case is judged by whether the captured result and the held outputs stay unchanged.

// File: rtl/sla_pkg.sv
`timescale 1ns/1ps
package sla_pkg;
  localparam int CH  = 4;
  localparam int CIW = $clog2(CH);
  localparam int CNW = $clog2(CH + 1);

  typedef struct packed {
    logic           load;
    logic           visit;
    logic [CIW-1:0] chIdx;
  } ctrlStrobe_t;

  function automatic logic [CIW-1:0] ringRight(input logic [CIW-1:0] idx);
    return (idx == CIW'(CH - 1)) ? '0 : idx + 1'b1;
  endfunction

  function automatic logic [CIW-1:0] ringLeft(input logic [CIW-1:0] idx);
    return (idx == '0) ? CIW'(CH - 1) : idx - 1'b1;
  endfunction
endpackage

// File: rtl/sla_lend_rule.sv
`timescale 1ns/1ps
module sla_lend_rule
  import sla_pkg::*;
#(
  parameter int DW = 4,
  parameter int OW = DW + 2
) (
  input  logic [CIW-1:0] curIdx,
  input  logic [CH-1:0]  hotspot,
  input  logic [CH-1:0]  inUse,
  input  logic [DW-1:0]  nomDepth,
  input  logic [OW-1:0]  remRight,
  input  logic [OW-1:0]  remLeft,
  output logic [OW-1:0]  amtRight,
  output logic [OW-1:0]  amtLeft
);
  logic [CNW-1:0] hsCount;
  logic [OW-1:0]  fullAmt;
  logic [OW-1:0]  keepOneAmt;
  logic [CIW-1:0] rIdx;
  logic [CIW-1:0] lIdx;

  function automatic logic [OW-1:0] capTo(input logic [OW-1:0] want,
                                          input logic [OW-1:0] have);
    return (want > have) ? have : want;
  endfunction

  always_comb begin
    hsCount = '0;
    for (int i = 0; i < CH; i++) hsCount = hsCount + CNW'(hotspot[i]);
  end

  assign fullAmt    = OW'(nomDepth);
  assign keepOneAmt = (nomDepth == '0) ? '0 : OW'(nomDepth) - 1'b1;
  assign rIdx       = ringRight(curIdx);
  assign lIdx       = ringLeft(curIdx);

  always_comb begin
    amtRight = '0;
    amtLeft  = '0;
    if (hotspot[curIdx]) begin
      if (hsCount == CNW'(1)) begin
        amtRight = capTo(inUse[rIdx] ? keepOneAmt : fullAmt, remRight);
        amtLeft  = capTo(inUse[lIdx] ? keepOneAmt : fullAmt, remLeft);
      end else if (hsCount == CNW'(2)) begin
        if (!inUse[rIdx])
          amtRight = capTo(fullAmt, remRight);
        else if (!hotspot[rIdx])
          amtRight = capTo(keepOneAmt, remRight);
        else if (!inUse[lIdx])
          amtLeft = capTo(fullAmt, remLeft);
        else
          amtLeft = capTo(keepOneAmt, remLeft);
      end
    end
  end
endmodule

// File: rtl/sla_datapath.sv
`timescale 1ns/1ps
module sla_datapath
  import sla_pkg::*;
#(
  parameter int DW = 4,
  parameter int OW = DW + 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [CH-1:0]    hotspotIn,
  input  logic [CH-1:0]    inUseIn,
  input  logic [DW-1:0]    nomDepthIn,
  output logic [CH*OW-1:0] depthFlat
);
  localparam int SW = OW + 2;

  logic [CH-1:0]  hsR;
  logic [CH-1:0]  useR;
  logic [DW-1:0]  nomR;
  logic [OW-1:0]  depth [CH];
  logic [CIW-1:0] rIdx;
  logic [CIW-1:0] lIdx;
  logic [OW-1:0]  amtRight;
  logic [OW-1:0]  amtLeft;
  logic [SW-1:0]  depthSum;
  logic [CNW-1:0] hsCount;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hsR  <= '0;
      useR <= '0;
      nomR <= '0;
    end else if (strobe.load) begin
      hsR  <= hotspotIn;
      useR <= inUseIn;
      nomR <= nomDepthIn;
    end
  end

  assign rIdx = ringRight(strobe.chIdx);
  assign lIdx = ringLeft(strobe.chIdx);

  sla_lend_rule #(.DW(DW), .OW(OW)) u_rule (
    .curIdx  (strobe.chIdx),
    .hotspot (hsR),
    .inUse   (useR),
    .nomDepth(nomR),
    .remRight(depth[rIdx]),
    .remLeft (depth[lIdx]),
    .amtRight(amtRight),
    .amtLeft (amtLeft)
  );

  for (genvar g = 0; g < CH; g++) begin : g_slot
    logic [OW:0] nxt;
    always_comb begin
      nxt = {1'b0, depth[g]};
      if (strobe.chIdx == CIW'(g)) nxt = nxt + {1'b0, amtRight} + {1'b0, amtLeft};
      if (rIdx == CIW'(g))         nxt = nxt - {1'b0, amtRight};
      if (lIdx == CIW'(g))         nxt = nxt - {1'b0, amtLeft};
    end

    always_ff @(posedge clk) begin
      if (!rstN)             depth[g] <= '0;
      else if (strobe.load)  depth[g] <= OW'(nomDepthIn);
      else if (strobe.visit) depth[g] <= nxt[OW-1:0];
    end

    assign depthFlat[g*OW +: OW] = depth[g];
  end

  always_comb begin
    depthSum = '0;
    hsCount  = '0;
    for (int i = 0; i < CH; i++) begin
      depthSum = depthSum + SW'(depth[i]);
      hsCount  = hsCount + CNW'(hsR[i]);
    end
  end

  // R8
  slot_sum_chk: assert property (@(posedge clk) disable iff (!rstN)
    depthSum == (SW'(nomR) << 2));

  // R4
  no_lend_crowded_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.visit && hsCount >= CNW'(3)) |=> $stable(depthFlat));

  // R3
  no_lend_calm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.visit && hsCount == '0) |=> $stable(depthFlat));
endmodule

// File: rtl/sla_ctrl.sv
`timescale 1ns/1ps
module sla_ctrl
  import sla_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output ctrlStrobe_t strobe,
  output logic        busy,
  output logic        done
);
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} ctrlState_t;

  ctrlState_t     state;
  logic [CIW-1:0] idx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else begin
      case (state)
        ST_RUN: begin
          if (idx == CIW'(CH - 1)) begin
            state <= ST_DONE;
            idx   <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: begin
          if (start) begin
            state <= ST_RUN;
            idx   <= '0;
          end
        end
      endcase
    end
  end

  always_comb begin
    strobe.load  = start && (state != ST_RUN);
    strobe.visit = (state == ST_RUN);
    strobe.chIdx = idx;
  end

  assign busy = (state == ST_RUN);
  assign done = (state == ST_DONE);

  // R2
  visit_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.visit && strobe.chIdx != CIW'(CH - 1)) |=>
      (strobe.visit && strobe.chIdx == $past(strobe.chIdx) + 1'b1));

  // R2
  finish_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.visit && strobe.chIdx == CIW'(CH - 1)) |=> (done && !busy));

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);
endmodule

// File: rtl/slot_lend_allocator.sv
`timescale 1ns/1ps
module slot_lend_allocator
  import sla_pkg::*;
#(
  parameter int DW = 4,
  localparam int OW = DW + 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CH-1:0]    hotspotIn,
  input  logic [CH-1:0]    inUseIn,
  input  logic [DW-1:0]    nomDepth,
  output logic [CH*OW-1:0] depthOut,
  output logic             busy,
  output logic             done
);
  ctrlStrobe_t strobe;

  sla_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .strobe(strobe),
    .busy  (busy),
    .done  (done)
  );

  sla_datapath #(.DW(DW), .OW(OW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .hotspotIn (hotspotIn),
    .inUseIn   (inUseIn),
    .nomDepthIn(nomDepth),
    .depthFlat (depthOut)
  );

  // R9
  depth_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> $stable(depthOut));

  // R2
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));
endmodule

// File: tb/tb_slot_lend_allocator.sv
`timescale 1ns/1ps
module tb_slot_lend_allocator;
  localparam int DW = 4;
  localparam int OW = DW + 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [3:0]    hotspotIn = '0;
  logic [3:0]    inUseIn = '0;
  logic [DW-1:0] nomDepth = '0;
  logic [4*OW-1:0] depthOut;
  logic          busy;
  logic          done;

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;

  typedef struct {
    int    expD[4];
    int    t0;
    string req;
    string name;
  } item_t;

  item_t sbQ[$];
  item_t curItem;
  logic  prevDone = 1'b0;
  int    lastExp[4];

  slot_lend_allocator #(.DW(DW)) dut (
    .clk(clk), .rstN(rstN), .start(start), .hotspotIn(hotspotIn),
    .inUseIn(inUseIn), .nomDepth(nomDepth), .depthOut(depthOut),
    .busy(busy), .done(done)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int depthOf(input int ch);
    return int'(depthOut[ch*OW +: OW]);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Expected depths derived from R3..R7 and R10, applied in visit order.
  function automatic void predict(input logic [3:0] hs, input logic [3:0] use_,
                                  input int d, output int e[4]);
    int cnt;
    int dm1;
    cnt = $countones(hs);
    dm1 = (d > 0) ? d - 1 : 0;
    for (int i = 0; i < 4; i++) e[i] = d;
    for (int i = 0; i < 4; i++) begin
      int r;
      int l;
      int a;
      r = (i + 1) % 4;
      l = (i + 3) % 4;
      if (hs[i] && cnt == 1) begin
        a = use_[r] ? dm1 : d; if (a > e[r]) a = e[r]; e[i] += a; e[r] -= a;
        a = use_[l] ? dm1 : d; if (a > e[l]) a = e[l]; e[i] += a; e[l] -= a;
      end else if (hs[i] && cnt == 2) begin
        if (!use_[r])      begin a = d;   if (a > e[r]) a = e[r]; e[i] += a; e[r] -= a; end
        else if (!hs[r])   begin a = dm1; if (a > e[r]) a = e[r]; e[i] += a; e[r] -= a; end
        else if (!use_[l]) begin a = d;   if (a > e[l]) a = e[l]; e[i] += a; e[l] -= a; end
        else               begin a = dm1; if (a > e[l]) a = e[l]; e[i] += a; e[l] -= a; end
      end
    end
  endfunction

  // Monitor: compares each completed pass against the scoreboard head.
  always @(negedge clk) begin
    if (rstN && done && !prevDone) begin
      if (sbQ.size() == 0) begin
        chk(1'b0, "R2", "unexpected done", 1, 0);
      end else begin
        int sum;
        curItem = sbQ.pop_front();
        sum = 0;
        chk(cyc - curItem.t0 == 5, "R2", {curItem.name, " latency"}, cyc - curItem.t0, 5);
        for (int i = 0; i < 4; i++) begin
          chk(depthOf(i) == curItem.expD[i], curItem.req,
              $sformatf("%s depth ch%0d", curItem.name, i), depthOf(i), curItem.expD[i]);
          sum += depthOf(i);
          lastExp[i] = curItem.expD[i];
        end
        chk(sum == curItem.expD[0] + curItem.expD[1] + curItem.expD[2] + curItem.expD[3],
            "R8", {curItem.name, " sum"}, sum,
            curItem.expD[0] + curItem.expD[1] + curItem.expD[2] + curItem.expD[3]);
      end
    end
    prevDone = done;
  end

  // Driver: push the expected result, then issue the start pulse.
  task automatic pushAndStart(input string name, input string req, input logic [3:0] hs,
                              input logic [3:0] use_, input int d);
    item_t it;
    @(negedge clk);
    hotspotIn = hs;
    inUseIn   = use_;
    nomDepth  = DW'(d);
    predict(hs, use_, d, it.expD);
    it.t0   = cyc;
    it.req  = req;
    it.name = name;
    sbQ.push_back(it);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic runCase(input string name, input string req, input logic [3:0] hs,
                         input logic [3:0] use_, input int d);
    pushAndStart(name, req, hs, use_, d);
    wait (sbQ.size() == 0 && done);
    @(negedge clk);
  endtask

  initial begin
    #100000;
    chk(1'b0, "R2", "watchdog expired", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int i = 0; i < 4; i++) chk(depthOf(i) == 0, "R1", "reset depth", depthOf(i), 0);
    chk(done == 1'b0, "R1", "reset done", int'(done), 0);
    chk(busy == 1'b0, "R1", "reset busy", int'(busy), 0);
    rstN = 1'b1;

    runCase("calm", "R3", 4'b0000, 4'b1111, 4);
    runCase("one hs ch2 busy nbrs", "R5", 4'b0100, 4'b1111, 4);
    runCase("one hs ch0 mixed nbrs", "R5", 4'b0001, 4'b1101, 4);
    runCase("one hs ch3 idle nbrs", "R5", 4'b1000, 4'b1010, 4);
    runCase("two hs 0,2 busy", "R6", 4'b0101, 4'b1111, 4);
    runCase("two hs 0,2 idle right", "R6", 4'b0101, 4'b0101, 4);
    runCase("two hs 0,1 left idle", "R6", 4'b0011, 4'b0111, 4);
    runCase("two hs 0,1 left busy", "R6", 4'b0011, 4'b1111, 4);
    runCase("two hs 3,0 order", "R10", 4'b1001, 4'b1110, 4);
    runCase("three hs", "R4", 4'b0111, 4'b1111, 4);
    runCase("four hs", "R4", 4'b1111, 4'b0000, 4);
    runCase("zero depth", "R7", 4'b0010, 4'b1111, 0);
    runCase("unit depth one hs", "R7", 4'b0010, 4'b1111, 1);
    runCase("unit depth order", "R10", 4'b1001, 4'b1110, 1);
    runCase("max depth one hs", "R5", 4'b0010, 4'b0000, 15);

    // R9: new inputs and a second start while busy do not disturb the pass
    pushAndStart("busy restart", "R9", 4'b0100, 4'b1111, 4);
    hotspotIn = 4'b0001;
    inUseIn   = 4'b0000;
    nomDepth  = DW'(7);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait (sbQ.size() == 0 && done);
    // R9: outputs held while done and no start, despite input changes
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      hotspotIn = 4'(k);
      inUseIn   = ~4'(k);
      chk(done == 1'b1, "R9", "done held", int'(done), 1);
      for (int i = 0; i < 4; i++)
        chk(depthOf(i) == lastExp[i], "R9", $sformatf("held depth ch%0d", i),
            depthOf(i), lastExp[i]);
    end

    runCase("after hold", "R5", 4'b0001, 4'b1111, 3);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule